// File: doc/BRIEF.md
# Parallel Gardner Symbol Synchronizer

This block recovers symbol timing from a stream of matched-filtered in-phase and quadrature samples that arrive several at a time on each clock. The stream carries a fixed 8 samples per symbol, and each input vector holds 16 samples per arm. Every clock the block forms one Gardner timing error per symbol slot in the vector. Each error is the midpoint sample times the difference between the current and the previous on-time samples, summed over both arms. The per-slot errors are averaged and scaled down by 64. The result drives a second-order loop filter made of a proportional path and an integrator, followed by a phase accumulator.

The integer sample part of the accumulator, taken modulo 8, is the sample-select index. That index picks which lanes of the vector are forwarded as soft symbols, two per clock on each arm. Timing is corrected only in whole-sample steps, and no interpolation is done. The detector does not depend on carrier phase, so the block can run ahead of carrier recovery. When the link carries single-arm modulation, the quadrature arm can be excluded from the error.

The last 8 samples of each vector are held over to the next clock. This lets the first symbol slot of a vector reach back one symbol into the previous vector.

Top module: `gardner_sync`

## Requirements
- R1: While reset is held and on the first cycle after it is released, every soft-symbol output and the select index read zero.
- R2: One clock after a vector is presented, soft symbol slot s on each arm equals input lane (idx + 8·s) of that vector, where idx is the value of sym_idx in that same cycle. Lane j occupies bits [12·j+11 : 12·j] of the input bus.
- R3: If every sample on both arms holds one constant value, the timing error is zero and the select index stays at its reset value of 0.
- R4: The error fed to the loop lies between the smallest and the largest of the per-slot Gardner errors of that clock.
- R5: A positive timing error, which means late sampling, moves the index down. A negative error moves it up. Starting from index 0, a signal whose symbol centres sit 1 to 3 lanes later is first met by a step up to 1, and one whose centres sit 1 to 3 lanes earlier is first met by a step to 7.
- R6: For an alternating-symbol pulse train with a constant offset of 0, 1, 2, 3, 5, 6 or 7 lanes, the index settles to that offset. Over the last 256 clocks of a 3000-clock run, it equals the offset on at least 200 clocks. On every clock where it equals the offset, each soft symbol is exactly the symbol centre value of ±512.
- R7: From one clock to the next, the select index changes by at most one sample, modulo 8. This includes the wraps 7→0 and 0→7.
- R8: With bpsk_mode high, the quadrature arm contributes nothing to the timing error, so a quadrature-only pulse train leaves the index at 0. With bpsk_mode low, the same stream pulls the index to its offset.
- R9: On a clock whose averaged error is zero, the loop integrator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, one sample vector per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bpsk_mode | input | 1 | High: drop the quadrature arm from the timing error |
| in_i | input | 192 | 16 in-phase lanes of 12-bit signed samples, lane 0 oldest |
| in_q | input | 192 | 16 quadrature lanes, same layout |
| sym_i | output | 24 | Two in-phase soft symbols, slot 0 in the low 12 bits |
| sym_q | output | 24 | Two quadrature soft symbols, same layout |
| sym_idx | output | 3 | Lane offset used to pick the symbols now on sym_i/sym_q |

## Verification
The soft symbols and sym_idx come from one register stage, so both reflect the vector that was on the inputs at the previous rising edge. The bench reads them 2 ns after that edge and compares them with the vector it drove just before it. The loop needs one further edge to fold a vector's error into the phase, so changes of the index are judged clock by clock (R7) or over settled windows (R6, R8) rather than at a fixed cycle. The R1 reset values are read in the window between the release of reset and the next edge.

// File: rtl/gsync_pkg.sv
`timescale 1ns/1ps
package gsync_pkg;
  typedef logic signed [63:0] wide_t;

  // midpoint sample times the change between on-time samples
  function automatic wide_t gardner_term(input wide_t mid, input wide_t now_s, input wide_t prev_s);
    return mid * (now_s - prev_s);
  endfunction

  // keep one loop step strictly below a whole sample
  function automatic wide_t clamp_step(input wide_t v, input int unsigned frac);
    wide_t lim;
    lim = (wide_t'(1) <<< frac) - 1;
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic wide_t scale_down(input wide_t v, input int unsigned sh);
    return v >>> sh;
  endfunction
endpackage

// File: rtl/gsync_window.sv
`timescale 1ns/1ps
module gsync_window #(
  parameter int DW    = 12,
  parameter int SPS   = 8,
  parameter int LANES = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES*DW-1:0]      in_i,
  input  logic [LANES*DW-1:0]      in_q,
  output logic [(SPS+LANES)*DW-1:0] win_i,
  output logic [(SPS+LANES)*DW-1:0] win_q
);
  localparam int HW = SPS * DW;

  logic [HW-1:0] hist_i, hist_q;

  // keep the newest SPS lanes for the next vector's first slot
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_i <= '0;
      hist_q <= '0;
    end else begin
      hist_i <= in_i[LANES*DW-1 -: HW];
      hist_q <= in_q[LANES*DW-1 -: HW];
    end
  end

  // window index 0..SPS-1 is history, SPS.. is the current vector
  assign win_i = {in_i, hist_i};
  assign win_q = {in_q, hist_q};
endmodule

// File: rtl/gsync_ted.sv
`timescale 1ns/1ps
module gsync_ted
  import gsync_pkg::*;
#(
  parameter int DW    = 12,
  parameter int SPS   = 8,
  parameter int LANES = 16,
  parameter int SLOT  = 0,
  parameter int EW    = 26
) (
  input  logic [(SPS+LANES)*DW-1:0] win_i,
  input  logic [(SPS+LANES)*DW-1:0] win_q,
  input  logic [$clog2(SPS)-1:0]    ptr,
  input  logic                      bpsk,
  output logic signed [EW-1:0]      err
);
  int    p_prev, p_mid, p_now;
  wide_t term_i, term_q, total;

  always_comb begin
    p_prev = SLOT * SPS + int'(ptr);
    p_mid  = p_prev + SPS / 2;
    p_now  = p_prev + SPS;
    term_i = gardner_term(wide_t'($signed(win_i[p_mid*DW +: DW])),
                          wide_t'($signed(win_i[p_now*DW +: DW])),
                          wide_t'($signed(win_i[p_prev*DW +: DW])));
    term_q = gardner_term(wide_t'($signed(win_q[p_mid*DW +: DW])),
                          wide_t'($signed(win_q[p_now*DW +: DW])),
                          wide_t'($signed(win_q[p_prev*DW +: DW])));
    total  = bpsk ? term_i : (term_i + term_q);
    err    = total[EW-1:0];
  end
endmodule

// File: rtl/gsync_loop.sv
`timescale 1ns/1ps
module gsync_loop
  import gsync_pkg::*;
#(
  parameter int EW      = 26,
  parameter int SPS     = 8,
  parameter int FRAC    = 16,
  parameter int GAIN_SH = 6,
  parameter int KA      = 256,
  parameter int KB      = 1,
  parameter int COEF_SH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [EW-1:0]   err_avg,
  output logic [$clog2(SPS)-1:0] ptr
);
  localparam int PTRW = $clog2(SPS);
  localparam int PHW  = PTRW + FRAC;

  logic [PHW-1:0] phase;
  wide_t intg, err_g, prop_t, int_t, step_raw, step_lim;

  always_comb begin
    err_g    = scale_down(wide_t'(err_avg), GAIN_SH);
    prop_t   = scale_down(err_g * KA, COEF_SH);
    int_t    = scale_down(err_g * KB, COEF_SH);
    step_raw = prop_t + intg;
    step_lim = clamp_step(step_raw, FRAC);
  end

  // second-order loop: integrator plus phase accumulator, late -> move down
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      intg  <= '0;
    end else begin
      intg  <= intg + int_t;
      phase <= phase - step_lim[PHW-1:0];
    end
  end

  assign ptr = phase[PHW-1 -: PTRW];

  // R7
  step_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (PTRW'(ptr - $past(ptr)) <= PTRW'(1)) || (PTRW'($past(ptr) - ptr) == PTRW'(1)));

  // R9
  intg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_avg == '0) |=> $stable(intg));
endmodule

// File: rtl/gardner_sync.sv
`timescale 1ns/1ps
module gardner_sync
  import gsync_pkg::*;
#(
  parameter int DW      = 12,
  parameter int SPS     = 8,
  parameter int LANES   = 16,
  parameter int FRAC    = 16,
  parameter int GAIN_SH = 6,
  parameter int KA      = 256,
  parameter int KB      = 1,
  parameter int COEF_SH = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 bpsk_mode,
  input  logic [LANES*DW-1:0]                  in_i,
  input  logic [LANES*DW-1:0]                  in_q,
  output logic [(LANES/SPS)*DW-1:0]            sym_i,
  output logic [(LANES/SPS)*DW-1:0]            sym_q,
  output logic [$clog2(SPS)-1:0]               sym_idx
);
  localparam int NSYM   = LANES / SPS;
  localparam int WIN    = SPS + LANES;
  localparam int PTRW   = $clog2(SPS);
  localparam int EW     = 2 * DW + 2;
  localparam int AVG_SH = $clog2(NSYM);

  logic [WIN*DW-1:0]        win_i, win_q;
  logic [PTRW-1:0]          ptr;
  logic signed [EW-1:0]     err_slot [NSYM];
  logic signed [EW-1:0]     err_avg;
  wide_t                    err_sum, err_min, err_max, avg_w;

  gsync_window #(.DW(DW), .SPS(SPS), .LANES(LANES)) u_win (
    .clk(clk), .rst(rst), .in_i(in_i), .in_q(in_q),
    .win_i(win_i), .win_q(win_q)
  );

  for (genvar s = 0; s < NSYM; s++) begin : g_ted
    gsync_ted #(.DW(DW), .SPS(SPS), .LANES(LANES), .SLOT(s), .EW(EW)) u_ted (
      .win_i(win_i), .win_q(win_q), .ptr(ptr), .bpsk(bpsk_mode),
      .err(err_slot[s])
    );
  end

  // mean of the per-slot errors
  always_comb begin
    err_sum = '0;
    err_min = wide_t'(err_slot[0]);
    err_max = wide_t'(err_slot[0]);
    for (int s = 0; s < NSYM; s++) begin
      err_sum = err_sum + wide_t'(err_slot[s]);
      if (wide_t'(err_slot[s]) < err_min) err_min = wide_t'(err_slot[s]);
      if (wide_t'(err_slot[s]) > err_max) err_max = wide_t'(err_slot[s]);
    end
    avg_w   = scale_down(err_sum, AVG_SH);
    err_avg = avg_w[EW-1:0];
  end

  gsync_loop #(.EW(EW), .SPS(SPS), .FRAC(FRAC), .GAIN_SH(GAIN_SH),
               .KA(KA), .KB(KB), .COEF_SH(COEF_SH)) u_loop (
    .clk(clk), .rst(rst), .err_avg(err_avg), .ptr(ptr)
  );

  // forward the on-time lanes chosen by the current index
  always_ff @(posedge clk) begin
    if (rst) begin
      sym_i   <= '0;
      sym_q   <= '0;
      sym_idx <= '0;
    end else begin
      for (int s = 0; s < NSYM; s++) begin
        sym_i[s*DW +: DW] <= win_i[(SPS + s*SPS + int'(ptr))*DW +: DW];
        sym_q[s*DW +: DW] <= win_q[(SPS + s*SPS + int'(ptr))*DW +: DW];
      end
      sym_idx <= ptr;
    end
  end

  // R1
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sym_idx == '0 && sym_i == '0 && sym_q == '0));

  // R4
  avg_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wide_t'(err_avg) >= err_min) && (wide_t'(err_avg) <= err_max));

  for (genvar s = 0; s < NSYM; s++) begin : g_chk
    // R2
    select_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (sym_i[s*DW +: DW] == $past(in_i[(s*SPS + int'(ptr))*DW +: DW])
                    && sym_q[s*DW +: DW] == $past(in_q[(s*SPS + int'(ptr))*DW +: DW])));
  end
endmodule

// File: tb/gardner_sync_test.sv
`timescale 1ns/1ps
module gardner_sync_test;
  localparam int DW = 12, SPS = 8, LANES = 16, NSYM = 2;

  logic clk = 1'b0, rst = 1'b1, bpsk = 1'b0;
  logic [LANES*DW-1:0] in_i = '0, in_q = '0;
  logic [NSYM*DW-1:0]  sym_i, sym_q;
  logic [2:0]          sym_idx;
  int n_tests = 0, n_fail = 0;
  int drv_i [LANES];
  int drv_q [LANES];

  always #10 clk = ~clk;

  gardner_sync uut (
    .clk(clk), .rst(rst), .bpsk_mode(bpsk), .in_i(in_i), .in_q(in_q),
    .sym_i(sym_i), .sym_q(sym_q), .sym_idx(sym_idx)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #4000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // alternating +/-512 symbols, linear pulse between centres at n = off mod 8
  function automatic int pulse(input longint n, input int off, input int pol);
    longint t, m;
    int r, d0;
    t  = n - off;
    m  = t / 8;
    r  = int'(t % 8);
    d0 = (m % 2 == 0) ? pol : -pol;
    return (d0 * (8 - r) - d0 * r) * 64;
  endfunction

  function automatic int slot_val(input logic [NSYM*DW-1:0] bus, input int s);
    return int'($signed(bus[s*DW +: DW]));
  endfunction

  task automatic put(input int j, input int vi, input int vq);
    in_i[j*DW +: DW] = DW'(vi);
    in_q[j*DW +: DW] = DW'(vq);
    drv_i[j] = vi;
    drv_q[j] = vq;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bpsk = 1'b0;
    for (int j = 0; j < LANES; j++) put(j, 0, 0);
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic drive_pulse(input longint base, input int off, input bit i_on, input bit q_on);
    for (int j = 0; j < LANES; j++)
      put(j, i_on ? pulse(base + j, off, 1) : 0, q_on ? pulse(base + j, off, -1) : 0);
  endtask

  task automatic run_conv(input int off);
    longint base = 64;
    int hits = 0, bad = 0, jumps = 0, first = 0;
    bit moved = 0;
    logic [2:0] last;
    do_reset();
    last = sym_idx;
    for (int c = 0; c < 3000; c++) begin
      drive_pulse(base, off, 1'b1, 1'b1);
      tick();
      if (!moved && sym_idx != 3'd0) begin
        moved = 1;
        first = int'(sym_idx);
      end
      if (!((3'(sym_idx - last) <= 3'd1) || (3'(last - sym_idx) == 3'd1))) jumps++;
      last = sym_idx;
      if (c >= 2744 && int'(sym_idx) == off) begin
        hits++;
        for (int s = 0; s < NSYM; s++) begin
          if (slot_val(sym_i, s) != pulse(base + off + s*8, off, 1)) bad++;
          if (slot_val(sym_q, s) != pulse(base + off + s*8, off, -1)) bad++;
        end
      end
      base += LANES;
    end
    // R4, R6, R9: averaged error through the loop settles on the offset
    check(hits >= 200, $sformatf("R6 R4 R9 settle off=%0d", off), hits, 256);
    check(bad == 0, $sformatf("R6 centre values off=%0d", off), bad, 0);
    check(jumps == 0, $sformatf("R7 single-sample steps off=%0d", off), jumps, 0);
    if (off != 0)
      check(first == ((off < 4) ? 1 : 7), $sformatf("R5 first step off=%0d", off),
            first, (off < 4) ? 1 : 7);
  endtask

  initial begin
    int bad, moves, hits;
    longint base;

    // R1: outputs after reset
    do_reset();
    check(sym_idx == 3'd0, "R1 index after reset", sym_idx, 0);
    check(sym_i == '0 && sym_q == '0, "R1 symbols after reset", sym_i, 0);

    // R3: constant input gives zero error
    for (int j = 0; j < LANES; j++) put(j, 300, -200);
    moves = 0;
    bad = 0;
    for (int c = 0; c < 100; c++) begin
      tick();
      if (sym_idx != 3'd0) moves++;
      if (slot_val(sym_i, 1) != 300 || slot_val(sym_q, 0) != -200) bad++;
    end
    check(moves == 0, "R3 index holds on constant input", moves, 0);
    check(bad == 0, "R3 constant symbols forwarded", bad, 0);

    // R2: lane selection against a varying ramp
    do_reset();
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      for (int j = 0; j < LANES; j++) begin
        int v = ((c * LANES + j) * 37) % 1000 - 500;
        put(j, v, -v);
      end
      tick();
      for (int s = 0; s < NSYM; s++) begin
        if (slot_val(sym_i, s) != drv_i[int'(sym_idx) + s*SPS]) bad++;
        if (slot_val(sym_q, s) != drv_q[int'(sym_idx) + s*SPS]) bad++;
      end
    end
    check(bad == 0, "R2 selected lanes", bad, 0);

    // R5, R6, R7 sweep over offsets (4 is the unstable half-symbol point)
    for (int off = 0; off < SPS; off++)
      if (off != 4) run_conv(off);

    // R8: quadrature-only stream with offset 2
    do_reset();
    bpsk = 1'b1;
    base = 64;
    moves = 0;
    for (int c = 0; c < 300; c++) begin
      drive_pulse(base, 2, 1'b0, 1'b1);
      tick();
      if (sym_idx != 3'd0) moves++;
      base += LANES;
    end
    check(moves == 0, "R8 quadrature ignored in bpsk mode", moves, 0);
    bpsk = 1'b0;
    hits = 0;
    for (int c = 0; c < 3000; c++) begin
      drive_pulse(base, 2, 1'b0, 1'b1);
      tick();
      if (c >= 2744 && sym_idx == 3'd2) hits++;
      base += LANES;
    end
    check(hits >= 200, "R8 quadrature used when bpsk low", hits, 256);

    summary();
  end
endmodule